// File: doc/BRIEF.md
# LIN Break Detector

This block watches a serial receive line for a LIN break: a low level held longer than a programmed time. It resynchronizes the raw pin, times each low with a reloadable down-counter that moves only on the cycles where a count-source enable is high, and flags a break when the counter expires while the line is still low. A low that ends early reloads the counter, and detection waits for the next low.

While armed, the block holds the receive input of a downstream UART at idle so that the break does not reach it as a framing error. A keep-mask select chooses what happens after a break: the block either stays masked and armed, or it releases the UART input and drops its ready flag. Software controls are a start level, a keep-mask select and three write-one-to-clear strobes. The strobes act on the break flag and on two other flags, bus collision and synch field, which other logic sets through their own set inputs. An interrupt pulse marks each rising edge of the break flag.

Top module: `lin_brk_det`

## Requirements
- R1: After reset, rdy_o, run_o, brk_o, coll_o, sfld_o and irq_o are 0, and uart_rxd_o is 1 while rxd_i is 1.
- R2: rxd_i passes through a two-flop synchronizer. While rdy_o is 0, uart_rxd_o follows rxd_i two clocks later. This also holds in the arming window after start_i has risen.
- R3: start_i high moves the block from idle to arming on the next clock. rdy_o then rises on the first later clock at which tick_i is 1, so it is never earlier than two clocks after start_i rises. When start_i is 0, rdy_o and run_o are 0 one clock later.
- R4: While rdy_o is 1, uart_rxd_o is 1 whatever the level of rxd_i.
- R5: The counter starts from init_i. While ready and the synchronized line is low, it decrements on each clock with tick_i high. The break is recognised at the tick where the count is 0, and brk_o rises one clock later. With tick_i held at 1 and init_i = N, brk_o rises N+4 clocks after rxd_i falls.
- R6: If the synchronized line goes high before expiry, the counter reloads init_i and no break is flagged. Lows do not accumulate. With tick_i at 1, a rxd_i low of N clocks gives no break and a low of N+1 clocks gives one.
- R7: After a break, or when ready is reached with the line already low, no break is counted until the line has been high and falls again.
- R8: With keep_mask_i = 1 the block stays ready after a break. With keep_mask_i = 0, rdy_o falls in the same clock that brk_o rises, and uart_rxd_o then follows the line until start_i is dropped and raised again.
- R9: run_o rises at the first clock with tick_i high after start_i takes effect (zero to one count-source cycle). It stays 1 until start_i falls.
- R10: irq_o is high for exactly one clock, in the clock where brk_o rises from 0.
- R11: Each of the three flags clears when 1 is written to its own bit of clr_i: bit 0 clears coll_o, bit 1 clears brk_o, bit 2 clears sfld_o. A 0 bit has no effect. A set in the same clock as a clear wins.
- R12: The counter does not move on clocks where tick_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Raw receive pin |
| tick_i | input | 1 | Count-source enable |
| start_i | input | 1 | Start control level |
| keep_mask_i | input | 1 | 1: stay masked after a break |
| init_i | input | CNT_W | Counter initial value |
| clr_i | input | 3 | Write-one-to-clear strobes (0 coll, 1 brk, 2 sfld) |
| coll_set_i | input | 1 | Sets the bus collision flag |
| sfld_set_i | input | 1 | Sets the synch field flag |
| uart_rxd_o | output | 1 | Gated receive line to the UART |
| rdy_o | output | 1 | Input masked, detection live |
| run_o | output | 1 | Timer running |
| brk_o | output | 1 | Break detected flag |
| coll_o | output | 1 | Bus collision flag |
| sfld_o | output | 1 | Synch field flag |
| irq_o | output | 1 | Break interrupt pulse |

## Verification
Every result has a fixed lag counted from the clock at which the bench changes an input. uart_rxd_o lags rxd_i by two clocks. rdy_o lags the first tick after arming by one clock. brk_o and irq_o lag the falling rxd_i by init+4 clocks when tick_i is 1. A flag clears or sets one clock after its strobe. The bench drives inputs one time unit after a rising edge and samples after stepping exactly those counts. Random low lengths are judged against the N versus N+1 boundary.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_LIVE, ST_DONE} brk_state_e;
  localparam int NFLG     = 3;
  localparam int FLG_COLL = 0;
  localparam int FLG_BRK  = 1;
  localparam int FLG_SFLD = 2;
endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  assign q_o = q[STAGES-1];
endmodule

// File: rtl/lin_brk_cnt.sv
module lin_brk_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         low_i,
  input  logic [W-1:0] init_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic         spent_q;
  logic         counting, expire;

  // spent: a low already used (or present at arming) must end first
  assign counting = en_i && low_i && !spent_q;
  assign expire   = counting && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      spent_q <= 1'b1;
      hit_o   <= 1'b0;
    end else begin
      hit_o <= expire;
      if (!en_i)       spent_q <= 1'b1;
      else if (!low_i) spent_q <= 1'b0;
      else if (expire) spent_q <= 1'b1;
      if (!counting || expire) cnt_q <= init_i;
      else if (tick_i)         cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lin_brk_ctl.sv
module lin_brk_ctl import lin_brk_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic            keep_i,
  input  logic            hit_i,
  input  logic [NFLG-1:0] set_i,
  input  logic [NFLG-1:0] clr_i,
  output logic            live_o,
  output logic            run_o,
  output logic [NFLG-1:0] flg_o,
  output logic            irq_o
);
  brk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!start_i) st_d = ST_IDLE;
    else unique case (st_q)
      ST_IDLE: st_d = ST_ARM;
      ST_ARM:  if (tick_i) st_d = ST_LIVE;
      ST_LIVE: if (hit_i && !keep_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      run_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_o <= hit_i && !flg_o[FLG_BRK];
      if (!start_i || st_q == ST_IDLE) run_o <= 1'b0;
      else if (tick_i)                 run_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_flg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)       flg_o[g] <= 1'b0;
      else if (set_i[g]) flg_o[g] <= 1'b1;
      else if (clr_i[g]) flg_o[g] <= 1'b0;
  end

  assign live_o = (st_q == ST_LIVE);
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det import lin_brk_pkg::*; #(
  parameter int CNT_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             keep_mask_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [NFLG-1:0]  clr_i,
  input  logic             coll_set_i,
  input  logic             sfld_set_i,
  output logic             uart_rxd_o,
  output logic             rdy_o,
  output logic             run_o,
  output logic             brk_o,
  output logic             coll_o,
  output logic             sfld_o,
  output logic             irq_o
);
  logic            rx_s, brk_hit, live;
  logic [NFLG-1:0] flg, set_v;

  lin_brk_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rx_s)
  );

  lin_brk_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .en_i(live), .low_i(!rx_s),
    .init_i, .hit_o(brk_hit)
  );

  always_comb begin
    set_v           = '0;
    set_v[FLG_COLL] = coll_set_i;
    set_v[FLG_BRK]  = brk_hit;
    set_v[FLG_SFLD] = sfld_set_i;
  end

  lin_brk_ctl u_ctl (
    .clk_i, .rst_ni, .start_i, .tick_i, .keep_i(keep_mask_i),
    .hit_i(brk_hit), .set_i(set_v), .clr_i, .live_o(live),
    .run_o, .flg_o(flg), .irq_o
  );

  assign rdy_o      = live;
  assign uart_rxd_o = live ? 1'b1 : rx_s;
  assign brk_o      = flg[FLG_BRK];
  assign coll_o     = flg[FLG_COLL];
  assign sfld_o     = flg[FLG_SFLD];
endmodule

// File: rtl/lin_brk_det_chk.sv
module lin_brk_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       tick_i,
  input logic [2:0] clr_i,
  input logic       uart_rxd_o,
  input logic       rdy_o,
  input logic       run_o,
  input logic       brk_o,
  input logic       irq_o,
  input logic       brk_hit
);
  a_r4_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> uart_rxd_o);
  a_r10_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r10_irq_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (brk_o && !$past(brk_o)));
  a_r3_rdy_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(tick_i && start_i));
  a_r3_stop_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!rdy_o && !run_o));
  a_r11_brk_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !brk_hit) |=> !brk_o);
endmodule

bind lin_brk_det lin_brk_det_chk u_chk (
  .clk_i, .rst_ni, .start_i, .tick_i, .clr_i, .uart_rxd_o,
  .rdy_o, .run_o, .brk_o, .irq_o, .brk_hit
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic rxd = 1, tick = 1, start = 0, keep = 1, coll_set = 0, sfld_set = 0;
  logic [W-1:0] init = 8'd5;
  logic [2:0] clr = '0;
  logic uart, rdy, run, brk, coll, sfld, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_brk_det #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick), .start_i(start),
    .keep_mask_i(keep), .init_i(init), .clr_i(clr), .coll_set_i(coll_set),
    .sfld_set_i(sfld_set), .uart_rxd_o(uart), .rdy_o(rdy), .run_o(run),
    .brk_o(brk), .coll_o(coll), .sfld_o(sfld), .irq_o(irq)
  );

  function automatic bit exp_brk(int n, int len);
    return len >= n + 1;
  endfunction
  function automatic int brk_lag(int n);
    return n + 4;
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_flags(logic [2:0] m);
    clr = m; step(1); clr = '0;
  endtask

  task automatic low_pulse(int len, bit alt);
    rxd = 0;
    for (int i = 0; i < len; i++) begin
      if (alt) tick = i[0];
      step(1);
    end
    rxd = 1; tick = 1;
    step(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, len, seed;
    seed = $urandom(32'd4242);
    step(3); rst_n = 1; step(1);
    chk("R1 rdy", rdy, 0); chk("R1 run", run, 0); chk("R1 brk", brk, 0);
    chk("R1 irq", irq, 0); chk("R1 coll", coll, 0); chk("R1 sfld", sfld, 0);
    chk("R1 uart", uart, 1);

    // R2 pass-through lag
    rxd = 0; step(1); chk("R2 lag1", uart, 1);
    step(1); chk("R2 lag2", uart, 0);
    rxd = 1; step(2); chk("R2 back", uart, 1);

    // R3 arming waits for a tick; R2 window stays open
    tick = 0; start = 1; step(4);
    chk("R3 no tick", rdy, 0); chk("R9 no tick", run, 0);
    rxd = 0; step(2); chk("R2 arm window", uart, 0);
    rxd = 1; step(2);
    tick = 1; step(1);
    chk("R3 ready", rdy, 1); chk("R9 run", run, 1);

    // R4 masking, R6 short low
    rxd = 0; step(3); chk("R4 masked", uart, 1);
    rxd = 1; step(3); chk("R6 short", brk, 0);

    // R5 exact break timing, R10 pulse
    rxd = 0; step(brk_lag(5) - 1);
    chk("R5 before", brk, 0); chk("R10 before", irq, 0);
    step(1);
    chk("R5 at", brk, 1); chk("R10 at", irq, 1); chk("R8 keep", rdy, 1);
    step(1); chk("R10 single", irq, 0);
    clr_flags(3'b010); chk("R11 brk clr", brk, 0);
    step(20); chk("R7 held low", brk, 0);
    rxd = 1; step(3); rxd = 0; step(brk_lag(5));
    chk("R7 new low", brk, 1);
    rxd = 1; clr_flags(3'b010); step(3);

    // R11 write-one-to-clear
    coll_set = 1; sfld_set = 1; step(1); coll_set = 0; sfld_set = 0;
    chk("R11 coll set", coll, 1); chk("R11 sfld set", sfld, 1);
    clr_flags(3'b010);
    chk("R11 zero coll", coll, 1); chk("R11 zero sfld", sfld, 1);
    clr_flags(3'b001); chk("R11 coll clr", coll, 0); chk("R11 sfld kept", sfld, 1);
    clr_flags(3'b100); chk("R11 sfld clr", sfld, 0);
    coll_set = 1; clr = 3'b001; step(1); coll_set = 0; clr = '0;
    chk("R11 set wins", coll, 1);
    clr_flags(3'b001); chk("R11 coll clr2", coll, 0);

    // R6 boundary and no accumulation
    low_pulse(5, 0); chk("R6 N low", brk, 0);
    low_pulse(6, 0); chk("R6 N+1 low", brk, 1);
    clr_flags(3'b010);
    rxd = 0; step(5); rxd = 1; step(1); rxd = 0; step(5); rxd = 1; step(6);
    chk("R6 no accumulate", brk, 0);

    // R12 tick gating
    low_pulse(6, 1); chk("R12 sparse short", brk, 0);
    low_pulse(21, 1); chk("R12 sparse long", brk, 1);
    clr_flags(3'b010); step(2);

    // R8 release after break
    keep = 0; rxd = 0; step(brk_lag(5) - 1);
    chk("R8 pre rdy", rdy, 1); chk("R8 pre uart", uart, 1); chk("R5 pre", brk, 0);
    step(1);
    chk("R8 brk", brk, 1); chk("R8 rdy drop", rdy, 0); chk("R8 uart low", uart, 0);
    rxd = 1; step(2); chk("R8 uart high", uart, 1);
    rxd = 0; step(2); chk("R8 still open", uart, 0); chk("R9 stays", run, 1);
    rxd = 1; start = 0; step(1);
    chk("R3 stop rdy", rdy, 0); chk("R9 stop run", run, 0);
    clr_flags(3'b010);
    keep = 1; start = 1; step(2); chk("R3 rearm", rdy, 1);
    step(2);

    // random low lengths
    for (int k = 0; k < 40; k++) begin
      n = 1 + int'($urandom % 12);
      init = W'(n); step(2);
      len = 1 + int'($urandom % (2 * n + 3));
      low_pulse(len, 0);
      chk("R6 R5 random", brk, exp_brk(n, len));
      clr_flags(3'b010); step(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule